// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the 32-bit program counter of a simple in-order core and selects the following fetch address on every clock edge. It takes the instruction word that was fetched at the current PC, along with the two register values read for a branch compare. From these it picks one of three next addresses. The first is the sequential address. The second is a target relative to the following instruction, for the equal and not-equal branches. The third is a region-absolute target, for the two jump opcodes.

The compare operands come from outside, as does the instruction itself. Stall freezes the counter. A synchronous reset returns it to address zero. The taken flag is combinational and refers to the instruction at the current PC.

Top module: `npc_unit`

## Requirements
- R1: After a synchronous reset (rst_i high at a clock edge), pc_o is 0x00000000, and it stays there while reset is held.
- R2: For any opcode (bits 31:26) other than 2, 3, 4 or 5, the next PC is pc_o + 4.
- R3: Opcode 4 branches when op_a_i equals op_b_i. The next PC is then pc_o + 4 + sign-extended(bits 15:0) × 4. Otherwise the next PC is pc_o + 4.
- R4: Opcode 5 branches when op_a_i differs from op_b_i. It uses the same target formula as R3. Otherwise the next PC is pc_o + 4.
- R5: The 16-bit branch offset is two's complement, so a negative offset moves the PC backwards.
- R6: Opcodes 2 and 3 always jump. The next PC is {bits 31:28 of pc_o+4, bits 25:0, 2'b00}. For example, a field value of 20000 gives 80000.
- R7: taken_o is high in the same cycle whenever the current instruction redirects the PC. That covers any jump, and any branch whose condition holds.
- R8: While stall_i is high and rst_i is low, pc_o keeps its value. Reset takes priority over stall.
- R9: The two low bits of pc_o are always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the PC |
| instr_i | input | 32 | Instruction fetched at pc_o |
| op_a_i | input | 32 | First compare operand (from the rs register) |
| op_b_i | input | 32 | Second compare operand (from the rt register) |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Current instruction redirects the PC |

## Verification
taken_o depends only on inputs and the current PC, so it is due in the same cycle that an instruction is presented. The new pc_o is due exactly one clock edge later, because a single register lies on that path. The bench drives inputs on the falling edge and checks taken_o before the next rising edge. For each instruction, the driver pushes the expected next PC into a queue. The monitor pops that value and compares it at the following falling edge, so every comparison happens one register stage after its stimulus.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_PC  = 32'h0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            stall_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic [31:0]     pc_o,
  output logic            taken_o
);
  localparam logic [5:0] OP_JMP  = 6'd2;
  localparam logic [5:0] OP_JAL  = 6'd3;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;

  logic [31:0] pc_q, seq_pc, br_tgt, jmp_tgt, next_pc;
  logic [5:0]  opc;
  logic        is_jump, is_br, cond;

  assign opc     = instr_i[31:26];
  assign seq_pc  = pc_q + 32'd4;
  assign br_tgt  = seq_pc + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
  assign jmp_tgt = {seq_pc[31:28], instr_i[25:0], 2'b00};

  assign is_jump = (opc == OP_JMP) || (opc == OP_JAL);
  assign is_br   = (opc == OP_BEQ) || (opc == OP_BNE);
  assign cond    = (opc == OP_BEQ) ? (op_a_i == op_b_i) : (op_a_i != op_b_i);
  assign taken_o = is_jump || (is_br && cond);

  assign next_pc = is_jump ? jmp_tgt : (taken_o ? br_tgt : seq_pc);

  always_ff @(posedge clk_i) begin
    if (rst_i)         pc_q <= RESET_PC;
    else if (!stall_i) pc_q <= next_pc;
  end

  assign pc_o = pc_q;

  logic seen_clk;
  always_ff @(posedge clk_i) seen_clk <= 1'b1;

  AST_RESET_PC: assert property (@(posedge clk_i) rst_i |=> pc_o == RESET_PC) else $error("reset"); // R1
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i) stall_i |=> $stable(pc_o)) else $error("stall"); // R8
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i || !seen_clk) pc_o[1:0] == 2'b00) else $error("align"); // R9
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (rst_i) (!stall_i && !taken_o) |=> pc_o == $past(pc_o) + 32'd4) else $error("seq"); // R2
  AST_JUMP_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i) (instr_i[31:27] == 5'b00001) |-> taken_o) else $error("jump"); // R7
endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
  logic clk = 0, rst, stall;
  logic [31:0] instr, a, b, pc;
  logic taken;
  int checks = 0, errors = 0;
  logic [31:0] expq[$];
  string tagq[$];
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  npc_unit dut_i (.clk_i(clk), .rst_i(rst), .stall_i(stall), .instr_i(instr),
                  .op_a_i(a), .op_b_i(b), .pc_o(pc), .taken_o(taken));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one instruction at negedge; expected next PC pushed to scoreboard
  task automatic step(input string tag, input logic [31:0] ins, input logic [31:0] va,
                      input logic [31:0] vb, input logic st, input logic exp_taken);
    logic [31:0] nxt, seq;
    logic [5:0] op;
    instr = ins; a = va; b = vb; stall = st;
    op = ins[31:26];
    seq = model_pc + 4;
    if (op == 2 || op == 3) nxt = {seq[31:28], ins[25:0], 2'b00};
    else if ((op == 4 && va == vb) || (op == 5 && va != vb))
      nxt = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
    else nxt = seq;
    if (st) nxt = model_pc;
    #1 chk({tag, " R7 taken"}, {31'd0, taken}, {31'd0, exp_taken});
    expq.push_back(nxt); tagq.push_back(tag);
    model_pc = nxt;
    @(negedge clk);
  endtask

  // monitor: compare PC at each negedge after a pushed item
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      string t;
      logic [31:0] e;
      e = expq.pop_front(); t = tagq.pop_front();
      chk(t, pc, e);
      chk({t, " R9 align"}, {30'd0, pc[1:0]}, 32'd0);
    end
  end

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; stall = 0; instr = 0; a = 0; b = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset", pc, 32'h0);
    @(negedge clk);
    chk("R1 reset hold", pc, 32'h0);
    rst = 0; model_pc = 0;
    step("R2 other opcode", 32'h012A4020, 1, 2, 0, 0);
    step("R2 addi", 32'h22D5FFCE, 0, 0, 0, 0);
    step("R3 beq taken", {6'd4, 5'd9, 5'd0, 16'd3}, 7, 7, 0, 1);
    step("R3 beq not taken", {6'd4, 5'd9, 5'd0, 16'd3}, 7, 8, 0, 0);
    step("R4 bne taken", {6'd5, 5'd8, 5'd21, 16'd2}, 1, 2, 0, 1);
    step("R4 bne not taken", {6'd5, 5'd8, 5'd21, 16'd2}, 5, 5, 0, 0);
    step("R5 beq negative", {6'd4, 5'd1, 5'd1, 16'hFFFB}, 3, 3, 0, 1);
    step("R6 jump 20000", {6'd2, 26'd20000}, 0, 0, 0, 1);
    step("R8 stall", {6'd2, 26'd5}, 0, 0, 1, 1);
    step("R8 stall branch", {6'd4, 10'd0, 16'd9}, 0, 0, 1, 1);
    step("R6 jal", {6'd3, 26'h3FFFFFF}, 0, 0, 0, 1);
    step("R2 after jal", 32'hFFFFFFFF, 0, 0, 0, 0);
    step("R5 bne negative", {6'd5, 10'd0, 16'h8000}, 1, 0, 0, 1);
    step("R2 seq", 32'h0, 0, 0, 0, 0);
    rst = 1; stall = 1;
    @(negedge clk);
    chk("R1 reset over stall R8", pc, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule